// File: doc/BRIEF.md
# Memory and I/O Chip-Select Decoder

This block turns the address and request strobes of a microprocessor bus (20-bit address, 8-bit data) into active-low chip selects for a ROM, a RAM and one auxiliary I/O device. The memory space is split into 4 KB pages, numbered by the top eight address bits. A ROM window starts at page 0 and a RAM window runs between two inclusive page bounds. Both windows are set through a small write-only register port. Where the two windows overlap, the ROM wins.

The auxiliary I/O select looks only at two low address bits and the I/O request strobe. It therefore repeats in every 256-byte page of the I/O space. It stays inactive during interrupt-acknowledge cycles. The auxiliary select shares one output pin with a daisy-chain interrupt-enable output. A configuration bit chooses which of the two drives the pin.

Every output is combinational from the bus inputs and the registered bounds. A register write therefore takes effect on the cycle that follows it.

Top module: `csdec_top`

## Requirements
- R1: After reset the ROM window covers every page, the RAM window is empty (lower bound 0xFF, upper bound 0x00), and the shared pin carries the auxiliary I/O select.
- R2: `rom_cs_n` is low exactly when `mreq_n` is low and page `addr[19:12]` is below the ROM top register. A ROM top value of 0 means that all 256 pages are ROM.
- R3: `ram_cs_n` is low exactly when `mreq_n` is low, the page lies in [RAM lower bound, RAM upper bound] with both ends included, and R4 does not suppress it.
- R4: When a page falls in both windows, only `rom_cs_n` goes low.
- R5: While `mreq_n` is high, `rom_cs_n` and `ram_cs_n` are both high.
- R6: With pin select 0, `aux_pin` is low exactly when `iorq_n` is low, `m1_n` is high and `addr[7:6]` is 2'b10 (I/O addresses xx80H to xxBFH). Bits 15 to 8 have no effect.
- R7: When `m1_n` and `iorq_n` are both low (interrupt acknowledge), the auxiliary select stays high.
- R8: When the pin-config register has bit 2 set, `aux_pin` equals `iei & ~irq_in_service`. With bit 2 clear, the pin returns to the I/O select.
- R9: A write on `reg_we` stores `reg_wdata` at index `reg_idx` on the clock edge. The index map is 0 = ROM top, 1 = RAM lower bound, 2 = RAM upper bound, 3 = pin config. The outputs reflect the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Bus address |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge strobe, active low |
| iei | input | 1 | Daisy-chain interrupt enable in |
| irq_in_service | input | 1 | An on-chip interrupt is being serviced |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index |
| reg_wdata | input | 8 | Register write data |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| aux_pin | output | 1 | Shared pin: auxiliary I/O select (active low) or interrupt enable out (active high) |

## Verification
The bench builds the block with its default parameters: a 20-bit address, 8-bit bounds that give 4 KB pages, and the match on bits 7:6 with suppression during M1. Eight-bit bounds put the top page 0xFF and the wrap-around meaning of a zero ROM top within easy reach. With them the bench can cover inclusive RAM edges at both ends, ROM-over-RAM overlap, and the same I/O select in distant I/O pages. A random phase then mixes writes and bus cycles against the behavioural model.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

   // register index map of the write port
   typedef enum logic [1:0] {
      REG_ROM_TOP = 2'd0,
      REG_RAM_LO  = 2'd1,
      REG_RAM_HI  = 2'd2,
      REG_PIN_CFG = 2'd3
   } csdec_reg_e;

   // how the window module treats its upper bound
   typedef enum int {
      WIN_EXCL_WRAP = 0,   // lo <= page < hi, hi == 0 means to the top
      WIN_INCL      = 1    // lo <= page <= hi
   } win_kind_e;

endpackage

// File: rtl/csdec_regs.sv
module csdec_regs #(
   parameter int DATA_W      = 8,
   parameter int BOUND_W     = 8,
   parameter int PIN_SEL_BIT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [1:0]         idx,
   input  logic [DATA_W-1:0]  wdata,
   output logic [BOUND_W-1:0] rom_top,
   output logic [BOUND_W-1:0] ram_lo,
   output logic [BOUND_W-1:0] ram_hi,
   output logic               pin_sel
);
   import csdec_pkg::*;

   localparam logic [BOUND_W-1:0] ROM_RST   = '0;   // whole space
   localparam logic [BOUND_W-1:0] RAM_LO_RST = '1;  // lo > hi: empty
   localparam logic [BOUND_W-1:0] RAM_HI_RST = '0;

   logic hit_rom, hit_lo, hit_hi, hit_cfg;

   always_comb begin
      hit_rom = we && (idx == REG_ROM_TOP);
      hit_lo  = we && (idx == REG_RAM_LO);
      hit_hi  = we && (idx == REG_RAM_HI);
      hit_cfg = we && (idx == REG_PIN_CFG);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rom_top <= ROM_RST;
         ram_lo  <= RAM_LO_RST;
         ram_hi  <= RAM_HI_RST;
         pin_sel <= 1'b0;
      end else begin
         if (hit_rom) rom_top <= wdata[BOUND_W-1:0];
         if (hit_lo)  ram_lo  <= wdata[BOUND_W-1:0];
         if (hit_hi)  ram_hi  <= wdata[BOUND_W-1:0];
         if (hit_cfg) pin_sel <= wdata[PIN_SEL_BIT];
      end
   end

   generate
      if (BOUND_W < DATA_W) begin : g_spare
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^wdata[DATA_W-1:BOUND_W];
      end
   endgenerate

   // R9: a ROM top write lands on the next edge
   a_r9_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == REG_ROM_TOP) |=> rom_top == $past(wdata[BOUND_W-1:0]));

   // R8: the pin function only changes through a config write
   a_r8_pin_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && idx == REG_PIN_CFG) |=> $stable(pin_sel));

endmodule

// File: rtl/csdec_window.sv
module csdec_window #(
   parameter int                   BOUND_W = 8,
   parameter csdec_pkg::win_kind_e KIND    = csdec_pkg::WIN_INCL
) (
   input  logic [BOUND_W-1:0] page,
   input  logic [BOUND_W-1:0] lo,
   input  logic [BOUND_W-1:0] hi,
   output logic               hit
);
   import csdec_pkg::*;

   logic above_lo;
   assign above_lo = (page >= lo);

   generate
      if (KIND == WIN_EXCL_WRAP) begin : g_excl
         logic below_hi;
         assign below_hi = (hi == '0) || (page < hi);
         assign hit = above_lo && below_hi;
      end else begin : g_incl
         assign hit = above_lo && (page <= hi);
      end
   endgenerate

   // R3: an inclusive window never hits when its bounds are reversed
   generate
      if (KIND == WIN_INCL) begin : g_chk
         always_comb begin
            a_r3_reversed_empty: assert (!(hit && (lo > hi)));
         end
      end
   endgenerate

endmodule

// File: rtl/csdec_io_decode.sv
module csdec_io_decode #(
   parameter int          FIELD_W  = 2,
   parameter logic [FIELD_W-1:0] MATCH = 2'b10,
   parameter bit          M1_BLOCK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] field,
   input  logic               iorq_n,
   input  logic               m1_n,
   output logic               io_cs_n
);
   logic field_ok;
   assign field_ok = (field == MATCH);

   generate
      if (M1_BLOCK) begin : g_block_ack
         assign io_cs_n = !(field_ok && !iorq_n && m1_n);
      end else begin : g_pass_ack
         logic unused_m1;
         assign unused_m1 = m1_n;
         assign io_cs_n = !(field_ok && !iorq_n);
      end
   endgenerate

   // R6: the select only goes low for an I/O request
   a_r6_needs_iorq: assert property (@(posedge clk) disable iff (!rst_n)
      !io_cs_n |-> !iorq_n);

   generate
      if (M1_BLOCK) begin : g_chk
         // R7: no select during an acknowledge cycle
         a_r7_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !m1_n |-> io_cs_n);
      end
   endgenerate

endmodule

// File: rtl/csdec_pin_mux.sv
module csdec_pin_mux (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_ieo,
   input  logic io_cs_n,
   input  logic iei,
   input  logic irq_in_service,
   output logic pin
);
   logic ieo;
   assign ieo = iei && !irq_in_service;
   assign pin = sel_ieo ? ieo : io_cs_n;

   // R8: chain output is blocked while an on-chip interrupt is serviced
   a_r8_ieo_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ieo && irq_in_service) |-> !pin);

endmodule

// File: rtl/csdec_top.sv
module csdec_top #(
   parameter int ADDR_W      = 20,
   parameter int DATA_W      = 8,
   parameter int BOUND_W     = 8,
   parameter int IO_HI       = 7,
   parameter int IO_LO       = 6,
   parameter int PIN_SEL_BIT = 2,
   parameter bit M1_BLOCK    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              mreq_n,
   input  logic              iorq_n,
   input  logic              m1_n,
   input  logic              iei,
   input  logic              irq_in_service,
   input  logic              reg_we,
   input  logic [1:0]        reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic              rom_cs_n,
   output logic              ram_cs_n,
   output logic              aux_pin
);
   import csdec_pkg::*;

   localparam int IO_W     = IO_HI - IO_LO + 1;
   localparam int PAGE_LSB = ADDR_W - BOUND_W;
   localparam logic [IO_W-1:0] IO_MATCH = {1'b1, {(IO_W-1){1'b0}}};

   generate
      if (BOUND_W > ADDR_W || BOUND_W > DATA_W) begin : g_bad_bound
         $error("csdec_top: BOUND_W must fit both ADDR_W and DATA_W");
      end
      if (IO_HI < IO_LO || IO_HI >= ADDR_W) begin : g_bad_io
         $error("csdec_top: I/O match field out of range");
      end
      if (PIN_SEL_BIT >= DATA_W) begin : g_bad_sel
         $error("csdec_top: PIN_SEL_BIT outside the data word");
      end
   endgenerate

   logic [BOUND_W-1:0] rom_top, ram_lo, ram_hi, page;
   logic               pin_sel, rom_hit, ram_hit, io_cs_n, unused_addr;

   assign page        = addr[ADDR_W-1:PAGE_LSB];
   assign unused_addr = ^addr;

   csdec_regs #(
      .DATA_W(DATA_W), .BOUND_W(BOUND_W), .PIN_SEL_BIT(PIN_SEL_BIT)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
      .rom_top(rom_top), .ram_lo(ram_lo), .ram_hi(ram_hi), .pin_sel(pin_sel)
   );

   csdec_window #(.BOUND_W(BOUND_W), .KIND(WIN_EXCL_WRAP)) i_rom_win (
      .page(page), .lo('0), .hi(rom_top), .hit(rom_hit)
   );

   csdec_window #(.BOUND_W(BOUND_W), .KIND(WIN_INCL)) i_ram_win (
      .page(page), .lo(ram_lo), .hi(ram_hi), .hit(ram_hit)
   );

   csdec_io_decode #(
      .FIELD_W(IO_W), .MATCH(IO_MATCH), .M1_BLOCK(M1_BLOCK)
   ) i_io (
      .clk(clk), .rst_n(rst_n), .field(addr[IO_HI:IO_LO]),
      .iorq_n(iorq_n), .m1_n(m1_n), .io_cs_n(io_cs_n)
   );

   csdec_pin_mux i_pin (
      .clk(clk), .rst_n(rst_n), .sel_ieo(pin_sel), .io_cs_n(io_cs_n),
      .iei(iei), .irq_in_service(irq_in_service), .pin(aux_pin)
   );

   always_comb begin
      rom_cs_n = !(!mreq_n && rom_hit);
      ram_cs_n = !(!mreq_n && ram_hit && !rom_hit);
   end

   // R5: no memory select without a memory request
   a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_n |-> (rom_cs_n && ram_cs_n));

   // R4: the two memory selects are never low together
   a_r4_rom_wins: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_cs_n |-> ram_cs_n);

   // R2: page 0 is always ROM during a memory request
   a_r2_page0_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && page == '0) |-> !rom_cs_n);

endmodule

// File: tb/test_csdec_top.sv
`timescale 1ns/1ps
module test_csdec_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] addr = '0;
   logic        mreq_n = 1'b1, iorq_n = 1'b1, m1_n = 1'b1;
   logic        iei = 1'b0, irq_in_service = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_idx = '0;
   logic [7:0]  reg_wdata = '0;
   logic        rom_cs_n, ram_cs_n, aux_pin;

   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   csdec_top i_csdec_top (
      .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
      .m1_n(m1_n), .iei(iei), .irq_in_service(irq_in_service),
      .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .aux_pin(aux_pin)
   );

   // behavioural model state
   int m_rom = 0, m_lo = 255, m_hi = 0, m_cfg = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rom <= 0; m_lo <= 255; m_hi <= 0; m_cfg <= 0;
      end else if (reg_we) begin
         case (reg_idx)
            2'd0: m_rom <= reg_wdata;
            2'd1: m_lo  <= reg_wdata;
            2'd2: m_hi  <= reg_wdata;
            default: m_cfg <= reg_wdata;
         endcase
      end
   end

   task automatic check(input string tag);
      int  pg = addr[19:12];
      bit  in_rom = (m_rom == 0) || (pg < m_rom);
      bit  in_ram = (pg >= m_lo) && (pg <= m_hi);
      bit  mem = !mreq_n;
      bit  exp_rom = !(mem && in_rom);
      bit  exp_ram = !(mem && in_ram && !in_rom);
      bit  io = !iorq_n && m1_n && (addr[7:6] == 2'b10);
      bit  exp_pin = m_cfg[2] ? (iei && !irq_in_service) : !io;
      checks++;
      if (rom_cs_n !== exp_rom || ram_cs_n !== exp_ram || aux_pin !== exp_pin) begin
         errors++;
         $display("FAIL %s addr=%h: got rom/ram/pin=%b%b%b expected %b%b%b",
                  tag, addr, rom_cs_n, ram_cs_n, aux_pin, exp_rom, exp_ram, exp_pin);
      end
   endtask

   task automatic bus(input logic [19:0] a, input bit mem, input bit io,
                      input bit m1, input string tag);
      @(negedge clk);
      reg_we = 0; addr = a; mreq_n = !mem; iorq_n = !io; m1_n = !m1;
      #1 check(tag);
   endtask

   task automatic wr(input logic [1:0] idx, input logic [7:0] d, input string tag);
      @(negedge clk);
      reg_we = 1; reg_idx = idx; reg_wdata = d;
      mreq_n = 1; iorq_n = 1; m1_n = 1;
      #1 check(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 check("R1");                       // outputs idle during reset
      @(negedge clk) rst_n = 1;
      // R1: reset state
      bus(20'hFFFFF, 1, 0, 0, "R1");
      bus(20'h00000, 1, 0, 0, "R1");
      bus(20'h80123, 1, 0, 0, "R1");
      bus(20'h00080, 0, 1, 0, "R1");
      // R5: no request
      bus(20'h00000, 0, 0, 0, "R5");
      bus(20'h00080, 0, 0, 1, "R5");
      // R2 / R9: ROM top = 0x10
      wr(2'd0, 8'h10, "R9");
      bus(20'h0FFFF, 1, 0, 0, "R2");
      bus(20'h10000, 1, 0, 0, "R2");
      bus(20'h0F000, 1, 0, 1, "R2");
      // R3: RAM 0x20..0x30
      wr(2'd1, 8'h20, "R9");
      wr(2'd2, 8'h30, "R9");
      bus(20'h1FFFF, 1, 0, 0, "R3");
      bus(20'h20000, 1, 0, 0, "R3");
      bus(20'h30FFF, 1, 0, 0, "R3");
      bus(20'h31000, 1, 0, 0, "R3");
      bus(20'h25000, 0, 0, 0, "R5");
      // RAM reaching the top page
      wr(2'd2, 8'hFF, "R9");
      bus(20'hFFFFF, 1, 0, 0, "R3");
      // R4: ROM overlaps RAM
      wr(2'd0, 8'h40, "R9");
      bus(20'h25000, 1, 0, 0, "R4");
      bus(20'h3F000, 1, 0, 0, "R4");
      bus(20'h40000, 1, 0, 0, "R4");
      // R2: zero means whole space again
      wr(2'd0, 8'h00, "R9");
      bus(20'hFF000, 1, 0, 0, "R2");
      // R6: I/O decode and page independence
      bus(20'h0007F, 0, 1, 0, "R6");
      bus(20'h00080, 0, 1, 0, "R6");
      bus(20'h000BF, 0, 1, 0, "R6");
      bus(20'h000C0, 0, 1, 0, "R6");
      bus(20'h0AB80, 0, 1, 0, "R6");
      bus(20'h0FF9C, 0, 1, 0, "R6");
      // R7: acknowledge cycle
      bus(20'h00080, 0, 1, 1, "R7");
      bus(20'h0ABA0, 0, 1, 1, "R7");
      // R8: pin switched to chain output
      wr(2'd3, 8'h04, "R8");
      for (int k = 0; k < 4; k++) begin
         iei = k[0]; irq_in_service = k[1];
         bus(20'h00080, 0, 1, 0, "R8");
      end
      wr(2'd3, 8'hFB, "R8");               // bit 2 clear: back to I/O select
      iei = 1; irq_in_service = 0;
      bus(20'h00080, 0, 1, 0, "R8");
      bus(20'h00040, 0, 1, 0, "R8");
      // random mix against the model
      for (int n = 0; n < 400; n++) begin
         iei = $urandom_range(0, 1); irq_in_service = $urandom_range(0, 1);
         if ($urandom_range(0, 5) == 0)
            wr(2'($urandom_range(0, 3)), 8'($urandom), "R9");
         else
            bus(20'($urandom), $urandom_range(0, 1) == 1,
                $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R3");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule